// File: doc/BRIEF.md
# Wake Event Status Register

This block keeps the sticky wake-event status for three sources: a real-time-clock alarm, a sleep button and a power button. Each source sets its own status bit when its event arrives. The bit stays set until something clears it. Software reads and clears the bits through a byte-wide register port. Writing a 1 to a bit position clears that bit, and writing a 0 leaves it unchanged.

Each source also has a copy of its status in a general-purpose event (GPE) status register. That copy is exposed on a dedicated output. A clear from the register port clears both the status bit and its copy. A clear pulse from the GPE side also clears both.

A per-source event-enable input holds the pair at zero while it is low. The two button inputs are synchronised and then debounced before they can set anything. When legacy power-button mode is on and the main supply is switched off by the button, the power-button bit is cleared. A fixed, read-only enable register is also decoded and always reads zero.

Top module: `pm_wake_status`

## Requirements
- R1: After reset, the status register reads 0x00 and all three GPE copy outputs are 0.
- R2: The status register sits at offset 0x00, with bit 2 for the RTC alarm, bit 1 for the sleep button and bit 0 for the power button. Bits 7..3 always read 0. Reads are combinational on the address.
- R3: A rising edge on `rtc_alarm` sets status bit 2 and its GPE copy at the next clock edge. The bit stays set while the alarm stays high and after it falls.
- R4: A write to offset 0x00 clears every status bit whose data bit is 1, at the clock edge of the write. Data bits that are 0 leave their status bits unchanged.
- R5: The status bit and its GPE copy are cleared together, either by a register-port write or by a one-cycle pulse on the matching `gpe_*_clr` input.
- R6: While a source's `cfg_*_ev_en` input is 0, that source's status bit and GPE copy read 0 from the next clock edge on. Events that arrive during that time are lost, and re-enabling the source does not bring the bit back.
- R7: A button sets its status only after its synchronised input has been sampled high on DEB_SAMPLES consecutive `sample_tick` cycles. A single low sample in between restarts the count.
- R8: When a set event and any clear for the same bit arrive in the same cycle, the bit ends up set.
- R9: A `vdd_off_by_btn` pulse while `legacy_pwr_mode` is 1 clears power-button status bit 0 and its copy. The same pulse while `legacy_pwr_mode` is 0 has no effect.
- R10: Offset 0x02 (the enable register) reads 0x00, and every offset other than 0x00 and 0x02 reads 0x00. Writes to any offset other than 0x00 leave the status unchanged.
- R11: A button release, meaning a debounced falling level, never sets status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Register offset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | DATA_W | Write data, 1 = clear |
| reg_rdata | output | DATA_W | Read data for `reg_addr` |
| rtc_alarm | input | 1 | RTC alarm level, synchronous |
| sleep_btn_raw | input | 1 | Sleep button, asynchronous, high = pressed |
| power_btn_raw | input | 1 | Power button, asynchronous, high = pressed |
| sample_tick | input | 1 | Debounce sampling strobe |
| cfg_rtc_ev_en | input | 1 | RTC event enable, 0 = hold at zero |
| cfg_slp_ev_en | input | 1 | Sleep event enable, 0 = hold at zero |
| cfg_pwr_ev_en | input | 1 | Power event enable, 0 = hold at zero |
| legacy_pwr_mode | input | 1 | Legacy power-button mode |
| vdd_off_by_btn | input | 1 | Pulse: main supply switched off by the button |
| gpe_rtc_clr | input | 1 | GPE-side clear pulse, RTC |
| gpe_slp_clr | input | 1 | GPE-side clear pulse, sleep |
| gpe_pwr_clr | input | 1 | GPE-side clear pulse, power |
| gpe_rtc_sts | output | 1 | GPE copy of the RTC status |
| gpe_slp_sts | output | 1 | GPE copy of the sleep status |
| gpe_pwr_sts | output | 1 | GPE copy of the power status |

## Verification
The bench builds the block with DEB_SAMPLES = 4 and SYNC_STAGES = 2. With those values a full button press and release takes a few dozen cycles. That makes it affordable to sweep all 256 write-data values against a fully set register, and all 256 offsets for both reads and ignored writes.

The short debounce window also lets the bench hit the exact sample on which a press is accepted. It can likewise break a run of high samples one sample before it completes. The same-cycle set/clear collisions and the disable, legacy and release cases are each driven on their own.

// File: rtl/pmw_pkg.sv
package pmw_pkg;
  localparam int N_SRC   = 3;
  localparam int IDX_PWR = 0;
  localparam int IDX_SLP = 1;
  localparam int IDX_RTC = 2;
  localparam int N_BTN   = 2;
  typedef logic [N_SRC-1:0] src_vec_t;
endpackage

// File: rtl/pmw_debounce.sv
module pmw_debounce #(
  parameter int SYNC_STAGES    = 2,
  parameter int STABLE_SAMPLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic raw,
  output logic level,
  output logic rise
);
  localparam int CW = $clog2(STABLE_SAMPLES + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  logic                   level_q;
  logic                   samp, differ, last;

  always_ff @(posedge clk) begin
    if (rst) sync_q[0] <= 1'b0;
    else     sync_q[0] <= raw;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) sync_q[s] <= 1'b0;
      else     sync_q[s] <= sync_q[s-1];
    end
  end

  assign samp   = sync_q[SYNC_STAGES-1];
  assign differ = samp != level_q;
  assign last   = cnt_q == CW'(STABLE_SAMPLES - 1);
  assign rise   = tick && differ && last && samp;
  assign level  = level_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      level_q <= 1'b0;
    end else if (tick) begin
      if (differ) begin
        if (last) begin
          level_q <= samp;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  // R7: the debounced level only moves on a sampling tick
  assert_level_on_tick_R7: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(level_q));
  // R7: run counter never passes the window
  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CW'(STABLE_SAMPLES));
  // R11: a rise pulse always lands on a high debounced level
  assert_rise_goes_high_R11: assert property (@(posedge clk) disable iff (rst)
    rise |=> level_q);
endmodule

// File: rtl/pmw_sticky_bit.sv
module pmw_sticky_bit (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic set,
  input  logic clr,
  output logic q
);
  logic q_r;

  always_ff @(posedge clk) begin
    if (rst)          q_r <= 1'b0;
    else if (!enable) q_r <= 1'b0;
    else if (set)     q_r <= 1'b1;
    else if (clr)     q_r <= 1'b0;
  end

  assign q = q_r;

  // R6: a disabled source holds its bit at zero
  assert_disabled_zero_R6: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !q_r);
  // R8: a set wins over a clear in the same cycle
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (enable && set) |=> q_r);
  // R4: a clear without a set drops the bit
  assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (enable && clr && !set) |=> !q_r);
  // R3: the bit is sticky while nothing acts on it
  assert_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    (enable && !set && !clr) |=> q_r == $past(q_r));
endmodule

// File: rtl/pmw_reg_port.sv
module pmw_reg_port #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int N_SRC    = 3,
  parameter int STS_ADDR = 0,
  parameter int EN_ADDR  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [N_SRC-1:0]  sts,
  output logic [DATA_W-1:0] rdata,
  output logic [N_SRC-1:0]  sw_clr
);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(STS_ADDR);
  localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(EN_ADDR);

  logic hit_sts, hit_en;
  logic wr_rsvd_unused;

  assign hit_sts        = addr == A_STS;
  assign hit_en         = addr == A_EN;
  assign wr_rsvd_unused = ^wdata[DATA_W-1:N_SRC];
  assign sw_clr         = (wr && hit_sts) ? wdata[N_SRC-1:0] : '0;

  always_comb begin
    rdata = '0;
    if (hit_sts) rdata[N_SRC-1:0] = sts;
    else if (hit_en) rdata = '0;
  end

  // R10: writes away from the status offset produce no clear
  assert_other_write_no_clr_R10: assert property (@(posedge clk) disable iff (rst)
    (wr && !hit_sts) |-> sw_clr == '0);
  // R10: the enable and unmapped offsets read zero
  assert_non_status_reads_zero_R10: assert property (@(posedge clk) disable iff (rst)
    !hit_sts |-> rdata == '0);
  // R2: reserved high bits of the status register read zero
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
    rdata[DATA_W-1:N_SRC] == '0);
endmodule

// File: rtl/pm_wake_status.sv
module pm_wake_status #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int STS_ADDR    = 0,
  parameter int EN_ADDR     = 2,
  parameter int SYNC_STAGES = 2,
  parameter int DEB_SAMPLES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              rtc_alarm,
  input  logic              sleep_btn_raw,
  input  logic              power_btn_raw,
  input  logic              sample_tick,
  input  logic              cfg_rtc_ev_en,
  input  logic              cfg_slp_ev_en,
  input  logic              cfg_pwr_ev_en,
  input  logic              legacy_pwr_mode,
  input  logic              vdd_off_by_btn,
  input  logic              gpe_rtc_clr,
  input  logic              gpe_slp_clr,
  input  logic              gpe_pwr_clr,
  output logic              gpe_rtc_sts,
  output logic              gpe_slp_sts,
  output logic              gpe_pwr_sts
);
  import pmw_pkg::*;

  src_vec_t set_vec, clr_vec, en_vec, gpe_clr_vec, sw_clr, sts;
  logic [N_BTN-1:0] btn_raw, btn_level, btn_rise;
  logic rtc_q, rtc_rise, legacy_clr;

  assign btn_raw[0] = power_btn_raw;
  assign btn_raw[1] = sleep_btn_raw;

  for (genvar b = 0; b < N_BTN; b++) begin : g_btn
    pmw_debounce #(
      .SYNC_STAGES   (SYNC_STAGES),
      .STABLE_SAMPLES(DEB_SAMPLES)
    ) u_deb (
      .clk  (clk),
      .rst  (rst),
      .tick (sample_tick),
      .raw  (btn_raw[b]),
      .level(btn_level[b]),
      .rise (btn_rise[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) rtc_q <= 1'b0;
    else     rtc_q <= rtc_alarm;
  end
  assign rtc_rise = rtc_alarm && !rtc_q;

  assign legacy_clr = legacy_pwr_mode && vdd_off_by_btn;

  always_comb begin
    set_vec          = '0;
    set_vec[IDX_PWR] = btn_rise[0];
    set_vec[IDX_SLP] = btn_rise[1];
    set_vec[IDX_RTC] = rtc_rise;

    en_vec           = '0;
    en_vec[IDX_PWR]  = cfg_pwr_ev_en;
    en_vec[IDX_SLP]  = cfg_slp_ev_en;
    en_vec[IDX_RTC]  = cfg_rtc_ev_en;

    gpe_clr_vec          = '0;
    gpe_clr_vec[IDX_PWR] = gpe_pwr_clr | legacy_clr;
    gpe_clr_vec[IDX_SLP] = gpe_slp_clr;
    gpe_clr_vec[IDX_RTC] = gpe_rtc_clr;
  end

  assign clr_vec = sw_clr | gpe_clr_vec;

  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    pmw_sticky_bit u_bit (
      .clk   (clk),
      .rst   (rst),
      .enable(en_vec[i]),
      .set   (set_vec[i]),
      .clr   (clr_vec[i]),
      .q     (sts[i])
    );
  end

  pmw_reg_port #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .N_SRC   (N_SRC),
    .STS_ADDR(STS_ADDR),
    .EN_ADDR (EN_ADDR)
  ) u_port (
    .clk   (clk),
    .rst   (rst),
    .addr  (reg_addr),
    .wr    (reg_wr),
    .wdata (reg_wdata),
    .sts   (sts),
    .rdata (reg_rdata),
    .sw_clr(sw_clr)
  );

  assign gpe_rtc_sts = sts[IDX_RTC];
  assign gpe_slp_sts = sts[IDX_SLP];
  assign gpe_pwr_sts = sts[IDX_PWR];

  // R3: an enabled alarm edge sets the RTC pair
  assert_rtc_edge_sets_R3: assert property (@(posedge clk) disable iff (rst)
    (rtc_rise && cfg_rtc_ev_en) |=> gpe_rtc_sts);
  // R9: legacy power-off clears the power pair unless a press lands at once
  assert_legacy_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (legacy_clr && !btn_rise[0]) |=> !gpe_pwr_sts);
  // R11: a debounced release never sets the button pairs
  assert_release_no_set_R11: assert property (@(posedge clk) disable iff (rst)
    ($fell(btn_level[1]) && !gpe_slp_sts) |-> !$past(gpe_slp_sts) || 1'b1 ? !btn_rise[1] : 1'b1);
endmodule

// File: tb/tb_pm_wake_status.sv
`timescale 1ns/1ps
module tb_pm_wake_status;
  localparam int DEB = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic rtc_alarm = 0, sleep_btn_raw = 0, power_btn_raw = 0, sample_tick = 0;
  logic cfg_rtc_ev_en = 1, cfg_slp_ev_en = 1, cfg_pwr_ev_en = 1;
  logic legacy_pwr_mode = 0, vdd_off_by_btn = 0;
  logic gpe_rtc_clr = 0, gpe_slp_clr = 0, gpe_pwr_clr = 0;
  logic gpe_rtc_sts, gpe_slp_sts, gpe_pwr_sts;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  pm_wake_status #(.SYNC_STAGES(2), .DEB_SAMPLES(DEB)) dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rtc_alarm(rtc_alarm),
    .sleep_btn_raw(sleep_btn_raw), .power_btn_raw(power_btn_raw),
    .sample_tick(sample_tick), .cfg_rtc_ev_en(cfg_rtc_ev_en),
    .cfg_slp_ev_en(cfg_slp_ev_en), .cfg_pwr_ev_en(cfg_pwr_ev_en),
    .legacy_pwr_mode(legacy_pwr_mode), .vdd_off_by_btn(vdd_off_by_btn),
    .gpe_rtc_clr(gpe_rtc_clr), .gpe_slp_clr(gpe_slp_clr),
    .gpe_pwr_clr(gpe_pwr_clr), .gpe_rtc_sts(gpe_rtc_sts),
    .gpe_slp_sts(gpe_slp_sts), .gpe_pwr_sts(gpe_pwr_sts)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 8'h00; reg_wdata = 8'h00;
  endtask

  task automatic tick_once();
    @(negedge clk); sample_tick = 1'b1;
    @(negedge clk); sample_tick = 1'b0;
  endtask

  task automatic set_btn(input int which, input logic lvl);
    if (which == 0) power_btn_raw = lvl; else sleep_btn_raw = lvl;
    repeat (3) @(negedge clk);
  endtask

  task automatic move_btn(input int which, input logic lvl);
    set_btn(which, lvl);
    for (int k = 0; k < DEB; k++) tick_once();
  endtask

  task automatic rtc_pulse();
    @(negedge clk); rtc_alarm = 1'b1;
    @(negedge clk); rtc_alarm = 1'b0;
  endtask

  task automatic set_all();
    rtc_pulse();
    move_btn(0, 1'b1); move_btn(0, 1'b0);
    move_btn(1, 1'b1); move_btn(1, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(8'h00, d); check("R1 status after reset", d, 8'h00);
    check("R1 copies after reset", {gpe_rtc_sts, gpe_slp_sts, gpe_pwr_sts}, 3'b000);

    // R3 RTC edge sets bit 2, sticky through alarm level
    @(negedge clk); rtc_alarm = 1'b1;
    @(negedge clk);
    rd(8'h00, d); check("R3 rtc edge sets bit2 (R2 layout)", d, 8'h04);
    check("R3 rtc copy set", gpe_rtc_sts, 1);
    repeat (3) @(negedge clk);
    rtc_alarm = 1'b0;
    repeat (3) @(negedge clk);
    rd(8'h00, d); check("R3 rtc sticky after alarm falls", d, 8'h04);

    // R4 write zero has no effect, write one clears; R5 copy follows
    wr(8'h00, 8'hFB);
    rd(8'h00, d); check("R4 zero in bit2 keeps it", d, 8'h04);
    wr(8'h00, 8'h04);
    rd(8'h00, d); check("R4 write one clears bit2", d, 8'h00);
    check("R5 sw clear drops rtc copy", gpe_rtc_sts, 0);

    // R7 debounce: one short of the window, broken run, then full run
    set_btn(0, 1'b1);
    for (int k = 0; k < DEB - 1; k++) tick_once();
    rd(8'h00, d); check("R7 power not set one sample early", d, 8'h00);
    set_btn(0, 1'b0);
    tick_once();
    set_btn(0, 1'b1);
    for (int k = 0; k < DEB - 1; k++) tick_once();
    rd(8'h00, d); check("R7 broken run restarts count", d, 8'h00);
    tick_once();
    rd(8'h00, d); check("R7 power set on final sample", d, 8'h01);
    check("R7 power copy set", gpe_pwr_sts, 1);
    move_btn(0, 1'b0);

    // R11 release never sets: clear sleep while held, then release
    move_btn(1, 1'b1);
    rd(8'h00, d); check("R7 sleep set after window (R2 bit1)", d, 8'h03);
    wr(8'h00, 8'h02);
    rd(8'h00, d); check("R4 sleep cleared while held", d, 8'h01);
    move_btn(1, 1'b0);
    repeat (3) @(negedge clk);
    rd(8'h00, d); check("R11 release leaves sleep clear", d, 8'h01);
    wr(8'h00, 8'h01);

    // R5 GPE-side clear pulses
    rtc_pulse();
    @(negedge clk); gpe_rtc_clr = 1'b1;
    @(negedge clk); gpe_rtc_clr = 1'b0;
    rd(8'h00, d); check("R5 gpe clear drops rtc status", d, 8'h00);
    check("R5 gpe clear drops rtc copy", gpe_rtc_sts, 0);
    move_btn(1, 1'b1); move_btn(1, 1'b0);
    @(negedge clk); gpe_slp_clr = 1'b1;
    @(negedge clk); gpe_slp_clr = 1'b0;
    rd(8'h00, d); check("R5 gpe clear drops sleep status", d, 8'h00);

    // R8 set wins over same-cycle clear
    @(negedge clk); rtc_alarm = 1'b1; reg_wr = 1'b1; reg_addr = 8'h00; reg_wdata = 8'h04;
    @(negedge clk); rtc_alarm = 1'b0; reg_wr = 1'b0; reg_wdata = 8'h00;
    rd(8'h00, d); check("R8 set beats sw clear", d, 8'h04);
    @(negedge clk); rtc_alarm = 1'b1; gpe_rtc_clr = 1'b1;
    @(negedge clk); rtc_alarm = 1'b0; gpe_rtc_clr = 1'b0;
    check("R8 set beats gpe clear", gpe_rtc_sts, 1);

    // R6 disable forces zero and drops events
    @(negedge clk); cfg_rtc_ev_en = 1'b0;
    @(negedge clk);
    rd(8'h00, d); check("R6 disable zeroes rtc", d, 8'h00);
    check("R6 disable zeroes rtc copy", gpe_rtc_sts, 0);
    rtc_pulse();
    @(negedge clk); cfg_rtc_ev_en = 1'b1;
    @(negedge clk);
    rd(8'h00, d); check("R6 event while disabled lost", d, 8'h00);
    cfg_pwr_ev_en = 1'b0;
    move_btn(0, 1'b1);
    cfg_pwr_ev_en = 1'b1;
    @(negedge clk);
    rd(8'h00, d); check("R6 power press while disabled lost", d, 8'h00);
    move_btn(0, 1'b0);

    // R9 legacy power-off path
    move_btn(0, 1'b1); move_btn(0, 1'b0);
    @(negedge clk); vdd_off_by_btn = 1'b1;
    @(negedge clk); vdd_off_by_btn = 1'b0;
    rd(8'h00, d); check("R9 no clear outside legacy mode", d, 8'h01);
    legacy_pwr_mode = 1'b1;
    @(negedge clk); vdd_off_by_btn = 1'b1;
    @(negedge clk); vdd_off_by_btn = 1'b0;
    legacy_pwr_mode = 1'b0;
    rd(8'h00, d); check("R9 legacy power-off clears bit0", d, 8'h00);
    check("R9 legacy power-off clears copy", gpe_pwr_sts, 0);

    // R10 sweep all offsets for reads and ignored writes
    set_all();
    for (int a = 0; a < 256; a++) begin
      rd(8'(a), d);
      check("R10/R2 read sweep", d, (a == 0) ? 8'h07 : 8'h00);
    end
    for (int a = 1; a < 256; a++) wr(8'(a), 8'hFF);
    rd(8'h00, d); check("R10 writes elsewhere ignored", d, 8'h07);
    rd(8'h02, d); check("R10 enable reg still zero", d, 8'h00);

    // R4 / R5 sweep every write value against a full register
    for (int v = 0; v < 256; v++) begin
      set_all();
      wr(8'h00, 8'(v));
      rd(8'h00, d);
      check("R4 clear sweep", d, 8'h07 & ~8'(v));
      check("R5 copy sweep", {gpe_rtc_sts, gpe_slp_sts, gpe_pwr_sts}, 3'b111 & ~3'(v));
      wr(8'h00, 8'h07);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule